// File: doc/BRIEF.md
# Processor Clock and Synchronizer Generator

This block turns a fast oscillator into the timing base of a 16-bit multiplexed-bus processor system. A three-phase state machine divides the oscillator by three. The result is a processor clock that is high for one oscillator period and low for two. A toggle stage halves that clock again to make a peripheral clock.

Two asynchronous requests are brought into the derived clock domain. The first is an active-low reset request. The second is a ready request from memory or I/O. The block presents them as a registered RESET and a registered READY, both aligned to processor-clock edges.

Every flop runs on the oscillator. The derived clocks are flop outputs, and logic that must act "on a CLK edge" uses one-cycle strobes from the divider. No clock is ever gated. The power-on reset `por_n_i` only sets the flops to a known state. The reset request leaves the divider running, so CLK keeps toggling while RESET is held.

The divider phases are named PH_HIGH, PH_LOW_A and PH_LOW_B, and they advance PH_HIGH to PH_LOW_A to PH_LOW_B and back to PH_HIGH. The power-on state is PH_LOW_B.

The reset sequencer has three states and steps only at CLK falling edges:
- RS_ASSERT holds RESET. It moves to RS_HOLD once the synchronized request reads released.
- RS_HOLD counts four falling edges and then moves to RS_RUN. It returns to RS_ASSERT if the request comes back.
- RS_RUN releases RESET. It returns to RS_ASSERT when the request reappears.

Top module: `clk_sync_gen`

## Requirements
- R1: CLK (`clk_o`) repeats with a period of three oscillator cycles: high for one, low for two. Its first high cycle starts at the first oscillator edge after `por_n_i` is released.
- R2: CLK and PCLK keep toggling while the reset request is active.
- R3: PCLK (`pclk_o`) changes only at the oscillator edge where CLK rises, and it changes at every such edge, so it runs at half the CLK frequency.
- R4: While `por_n_i` is low, the outputs are CLK=0, PCLK=0, READY=0 and RESET=1. RESET stays 1 while the reset request (`rst_req_n_i`=0) is active.
- R5: RESET changes only at the oscillator edge where CLK falls.
- R6: After the reset request is released, RESET stays high for at least four full CLK cycles. It falls on the fifth or sixth CLK falling edge counted from the release.
- R7: If the request returns while the hold count is running, RESET stays high. The full hold starts again after the next release.
- R8: READY equals `rdy_req_i` as sampled at a CLK rising edge, presented at the following CLK falling edge. READY changes only at CLK falling edges.
- R9: A ready pulse that does not cover an oscillator edge at which CLK rises does not change READY.
- R10: The READY path is independent of RESET. It keeps tracking while RESET is high, and it can change at the same edge at which RESET falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_i | input | 1 | Oscillator clock; every flop runs on its rising edge |
| por_n_i | input | 1 | Active-low power-on initialisation of all flops |
| rst_req_n_i | input | 1 | Asynchronous active-low reset request |
| rdy_req_i | input | 1 | Asynchronous ready request from memory or I/O |
| clk_o | output | 1 | Processor clock, one third of osc_i, one-third duty |
| pclk_o | output | 1 | Peripheral clock, half of clk_o |
| ready_o | output | 1 | Synchronized ready, changes on CLK falling edges |
| reset_o | output | 1 | Synchronized active-high reset, changes on CLK falling edges |

## Verification
RESET release and a READY change both happen at a CLK falling edge, so both can occur at the same oscillator edge.

To provoke this, the bench releases the reset request and then flips the ready request right after every CLK falling edge. This makes READY change at every falling edge, including the one at which RESET drops.

At that edge the bench checks three things:
- RESET has dropped.
- READY has taken the value a bench model predicts from the sampled request.
- The number of falling edges since release lies within the allowed hold window.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    // Phases of the divide-by-three processor clock
    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW_A = 2'd1,
        PH_LOW_B = 2'd2
    } div_phase_e;

    // States of the reset sequencer
    typedef enum logic [1:0] {
        RS_ASSERT = 2'd0,
        RS_HOLD   = 2'd1,
        RS_RUN    = 2'd2
    } rst_state_e;

endpackage

// File: rtl/clkgen_div3.sv
module clkgen_div3
    import clkgen_pkg::*;
(
    input  logic osc_i,
    input  logic por_n_i,
    output logic clk_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);

    div_phase_e phase_q;
    div_phase_e phase_nxt;
    logic       clk_q;

    always_comb begin
        unique case (phase_q)
            PH_HIGH:  phase_nxt = PH_LOW_A;
            PH_LOW_A: phase_nxt = PH_LOW_B;
            PH_LOW_B: phase_nxt = PH_HIGH;
            default:  phase_nxt = PH_HIGH;
        endcase
    end

    // State register
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            phase_q <= PH_LOW_B;
        end else begin
            phase_q <= phase_nxt;
        end
    end

    // Registered clock output, high only during PH_HIGH
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            clk_q <= 1'b0;
        end else begin
            clk_q <= (phase_nxt == PH_HIGH);
        end
    end

    // Strobes mark the oscillator edge at which CLK will rise or fall
    assign rise_stb_o = (phase_q == PH_LOW_B);
    assign fall_stb_o = (phase_q == PH_HIGH);
    assign clk_o      = clk_q;

endmodule

// File: rtl/clkgen_pclk.sv
module clkgen_pclk (
    input  logic osc_i,
    input  logic por_n_i,
    input  logic rise_stb_i,
    output logic pclk_o
);

    logic pclk_q;

    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            pclk_q <= 1'b0;
        end else if (rise_stb_i) begin
            pclk_q <= ~pclk_q;
        end
    end

    assign pclk_o = pclk_q;

endmodule

// File: rtl/clkgen_rdy_sync.sv
module clkgen_rdy_sync (
    input  logic osc_i,
    input  logic por_n_i,
    input  logic rdy_req_i,
    input  logic rise_stb_i,
    input  logic fall_stb_i,
    output logic ready_o
);

    logic stage_a_q;
    logic stage_b_q;

    // First stage captures the request with the CLK rising edge
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            stage_a_q <= 1'b0;
        end else if (rise_stb_i) begin
            stage_a_q <= rdy_req_i;
        end
    end

    // Second stage presents it at the following CLK falling edge
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            stage_b_q <= 1'b0;
        end else if (fall_stb_i) begin
            stage_b_q <= stage_a_q;
        end
    end

    assign ready_o = stage_b_q;

endmodule

// File: rtl/clkgen_rst_sync.sv
module clkgen_rst_sync
    import clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic osc_i,
    input  logic por_n_i,
    input  logic rst_req_n_i,
    input  logic fall_stb_i,
    output logic reset_o
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   req_s;
    rst_state_e             state_q;
    rst_state_e             state_nxt;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cnt_nxt;
    logic                   reset_q;

    // Synchronizer chain: one flop per stage, all starting at "request active"
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge osc_i or negedge por_n_i) begin
                if (!por_n_i) begin
                    chain_q[g] <= 1'b1;
                end else if (g == 0) begin
                    chain_q[g] <= ~rst_req_n_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign req_s = chain_q[SYNC_STAGES-1];

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            RS_ASSERT: begin
                cnt_nxt = '0;
                if (!req_s) begin
                    state_nxt = RS_HOLD;
                end
            end
            RS_HOLD: begin
                if (req_s) begin
                    state_nxt = RS_ASSERT;
                    cnt_nxt   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_nxt = RS_RUN;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            RS_RUN: begin
                cnt_nxt = '0;
                if (req_s) begin
                    state_nxt = RS_ASSERT;
                end
            end
            default: begin
                state_nxt = RS_ASSERT;
                cnt_nxt   = '0;
            end
        endcase
    end

    // State register, advanced only at CLK falling edges
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= RS_ASSERT;
            cnt_q   <= '0;
        end else if (fall_stb_i) begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Registered RESET output, updated with the state
    always_ff @(posedge osc_i or negedge por_n_i) begin
        if (!por_n_i) begin
            reset_q <= 1'b1;
        end else if (fall_stb_i) begin
            reset_q <= (state_nxt != RS_RUN);
        end
    end

    assign reset_o = reset_q;

endmodule

// File: rtl/clk_sync_gen.sv
module clk_sync_gen #(
    parameter int RST_SYNC_STAGES = 2,
    parameter int RST_HOLD_CYCLES = 4
) (
    input  logic osc_i,
    input  logic por_n_i,
    input  logic rst_req_n_i,
    input  logic rdy_req_i,
    output logic clk_o,
    output logic pclk_o,
    output logic ready_o,
    output logic reset_o
);

    logic rise_stb;
    logic fall_stb;

    clkgen_div3 u_div (
        .osc_i      (osc_i),
        .por_n_i    (por_n_i),
        .clk_o      (clk_o),
        .rise_stb_o (rise_stb),
        .fall_stb_o (fall_stb)
    );

    clkgen_pclk u_pclk (
        .osc_i      (osc_i),
        .por_n_i    (por_n_i),
        .rise_stb_i (rise_stb),
        .pclk_o     (pclk_o)
    );

    clkgen_rdy_sync u_rdy (
        .osc_i      (osc_i),
        .por_n_i    (por_n_i),
        .rdy_req_i  (rdy_req_i),
        .rise_stb_i (rise_stb),
        .fall_stb_i (fall_stb),
        .ready_o    (ready_o)
    );

    clkgen_rst_sync #(
        .SYNC_STAGES (RST_SYNC_STAGES),
        .HOLD_CYCLES (RST_HOLD_CYCLES)
    ) u_rst (
        .osc_i       (osc_i),
        .por_n_i     (por_n_i),
        .rst_req_n_i (rst_req_n_i),
        .fall_stb_i  (fall_stb),
        .reset_o     (reset_o)
    );

endmodule

// File: rtl/clk_sync_gen_chk.sv
module clk_sync_gen_chk (
    input logic osc_i,
    input logic por_n_i,
    input logic clk_o,
    input logic pclk_o,
    input logic ready_o,
    input logic reset_o
);

    // R1
    clk_high_one_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        clk_o |=> !clk_o);

    // R1
    clk_low_two_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        $fell(clk_o) |=> !clk_o);

    // R2
    clk_period_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        (!clk_o && !$past(clk_o)) |=> clk_o);

    // R3
    pclk_on_rise_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        !$stable(pclk_o) |-> $rose(clk_o));

    // R3
    pclk_every_rise_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        $rose(clk_o) |-> !$stable(pclk_o));

    // R5
    reset_on_fall_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        !$stable(reset_o) |-> $fell(clk_o));

    // R8
    ready_on_fall_chk: assert property (@(posedge osc_i) disable iff (!por_n_i)
        !$stable(ready_o) |-> $fell(clk_o));

endmodule

bind clk_sync_gen clk_sync_gen_chk u_chk (
    .osc_i   (osc_i),
    .por_n_i (por_n_i),
    .clk_o   (clk_o),
    .pclk_o  (pclk_o),
    .ready_o (ready_o),
    .reset_o (reset_o)
);

// File: tb/sim_clk_sync_gen.sv
`timescale 1ns/1ps
module sim_clk_sync_gen;

    logic osc = 1'b0;
    logic por_n = 1'b0;
    logic rst_req_n = 1'b0;
    logic rdy_req = 1'b0;
    logic clk_w, pclk_w, ready_w, reset_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side ready model and monitor state
    bit mon_en = 1'b0;
    logic m_a = 1'b0;
    logic m_b = 1'b0;
    logic clk_p = 1'b0;
    logic pclk_p = 1'b0;

    always #4 osc = ~osc;

    clk_sync_gen u0 (
        .osc_i       (osc),
        .por_n_i     (por_n),
        .rst_req_n_i (rst_req_n),
        .rdy_req_i   (rdy_req),
        .clk_o       (clk_w),
        .pclk_o      (pclk_w),
        .ready_o     (ready_w),
        .reset_o     (reset_w)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: samples before drivers change (drivers act 1 ns after the negedge)
    always @(negedge osc) begin
        if (mon_en) begin
            if (!clk_p && clk_w) m_a = rdy_req;
            if (clk_p && !clk_w) begin
                m_b = m_a;
                chk(ready_w == m_b, "R8 READY vs model", ready_w, m_b);
            end
            if (pclk_w != pclk_p)
                chk(!clk_p && clk_w, "R3 PCLK change off CLK rise", clk_w, 1);
        end
        clk_p  = clk_w;
        pclk_p = pclk_w;
    end

    task automatic step();
        @(negedge osc);
        #1;
    endtask

    task automatic t_reset_state();
        por_n = 1'b0; rst_req_n = 1'b0; rdy_req = 1'b0;
        repeat (3) step();
        chk(clk_w == 1'b0, "R4 CLK at power-on", clk_w, 0);
        chk(pclk_w == 1'b0, "R4 PCLK at power-on", pclk_w, 0);
        chk(ready_w == 1'b0, "R4 READY at power-on", ready_w, 0);
        chk(reset_w == 1'b1, "R4 RESET at power-on", reset_w, 1);
        por_n = 1'b1;
        mon_en = 1'b1;
        step();
        chk(clk_w == 1'b1, "R1 first CLK high after power-on", clk_w, 1);
    endtask

    task automatic t_clk_shape();
        // request still active: CLK must run (R2) with 1-high/2-low shape (R1)
        int guard = 0;
        while (!(clk_w == 1'b1) && guard < 10) begin step(); guard++; end
        for (int i = 1; i <= 9; i++) begin
            step();
            chk(clk_w == ((i % 3) == 0), "R1 R2 CLK shape during reset", clk_w, (i % 3) == 0);
        end
        chk(reset_w == 1'b1, "R4 RESET held by request", reset_w, 1);
    endtask

    task automatic t_pclk();
        logic p0;
        int guard = 0;
        while (!(clk_w == 1'b1) && guard < 10) begin step(); guard++; end
        p0 = pclk_w;
        repeat (3) step();
        chk(pclk_w == ~p0, "R3 PCLK toggles at next CLK rise", pclk_w, ~p0);
        repeat (3) step();
        chk(pclk_w == p0, "R3 PCLK period six oscillator cycles", pclk_w, p0);
    endtask

    task automatic t_reset_release();
        int falls = 0;
        bit dropped = 1'b0;
        logic cprev = clk_w;
        rst_req_n = 1'b1;
        for (int i = 0; i < 40 && !dropped; i++) begin
            step();
            if (cprev && !clk_w) falls++;
            if (!reset_w) begin
                dropped = 1'b1;
                chk(cprev && !clk_w, "R5 RESET drop at CLK fall", clk_w, 0);
                chk(falls >= 5 && falls <= 6, "R6 hold length in CLK falls", falls, 5);
            end
            cprev = clk_w;
        end
        chk(dropped, "R6 RESET released", dropped, 1);
    endtask

    task automatic t_reset_restart();
        int falls = 0;
        int lows = 0;
        logic cprev;
        rst_req_n = 1'b0;
        repeat (15) step();
        chk(reset_w == 1'b1, "R4 RESET reasserted by request", reset_w, 1);
        rst_req_n = 1'b1;
        cprev = clk_w;
        while (falls < 3) begin
            step();
            if (cprev && !clk_w) falls++;
            if (!reset_w) lows++;
            cprev = clk_w;
        end
        rst_req_n = 1'b0;
        repeat (30) begin
            step();
            if (!reset_w) lows++;
        end
        chk(lows == 0, "R7 RESET stays high on early re-request", lows, 0);
        t_reset_release();
    endtask

    task automatic t_ready_track();
        int n = 0;
        rdy_req = 1'b1;
        while (!ready_w && n < 12) begin step(); n++; end
        chk(ready_w == 1'b1, "R8 READY rises", ready_w, 1);
        chk(n <= 7, "R8 READY rise latency", n, 7);
        rdy_req = 1'b0;
        n = 0;
        while (ready_w && n < 12) begin step(); n++; end
        chk(ready_w == 1'b0, "R8 READY falls", ready_w, 0);
        chk(n <= 7, "R8 READY fall latency", n, 7);
    endtask

    task automatic t_ready_glitch();
        int highs = 0;
        int guard = 0;
        // clk_w high now means the next oscillator edge is a CLK fall
        while (!(clk_w == 1'b1) && guard < 10) begin step(); guard++; end
        rdy_req = 1'b1;
        step();
        rdy_req = 1'b0;
        repeat (9) begin
            step();
            if (ready_w) highs++;
        end
        chk(highs == 0, "R9 short ready pulse ignored", highs, 0);
    endtask

    task automatic t_overlap();
        int falls = 0;
        int chg_in_reset = 0;
        bit dropped = 1'b0;
        logic cprev, rprev;
        rst_req_n = 1'b0;
        repeat (15) step();
        rst_req_n = 1'b1;
        cprev = clk_w;
        rprev = ready_w;
        for (int i = 0; i < 40 && !dropped; i++) begin
            step();
            if (reset_w && ready_w != rprev) chg_in_reset++;
            if (!reset_w) begin
                dropped = 1'b1;
                chk(ready_w != rprev, "R10 READY changes at RESET drop edge", ready_w, !rprev);
                chk(falls + 1 >= 5 && falls + 1 <= 6, "R6 hold length with READY activity", falls + 1, 5);
            end
            if (cprev && !clk_w) begin
                falls++;
                rdy_req = ~rdy_req;
            end
            cprev = clk_w;
            rprev = ready_w;
        end
        chk(dropped, "R10 RESET released during READY activity", dropped, 1);
        chk(chg_in_reset >= 2, "R10 READY tracks while RESET high", chg_in_reset, 2);
        rdy_req = 1'b0;
        repeat (9) step();
    endtask

    initial begin
        t_reset_state();
        t_clk_shape();
        t_pclk();
        t_reset_release();
        t_ready_track();
        t_ready_glitch();
        t_reset_restart();
        t_overlap();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule